// File: doc/BRIEF.md
# VPW Serial Receive Filter and Symbol Decoder

This block is the receive half of a variable-pulse-width (VPW) Class B vehicle bus interface. It samples the serial receive line on a free-running interface clock and suppresses short noise with a saturating up/down counter filter. It then measures the length of every active and passive interval on the cleaned line. Each interval is sorted by its length into start-of-frame, a data bit, end-of-data or an invalid symbol. Data bits are collected into bytes, most significant bit first, and a CRC-8 runs over every byte of the frame.

The receive line is active high and must already be synchronous to `clk`. All widths are counted in interface clocks. With the default parameters (a clock near 1.05 MHz), a short symbol is nominally 67 clocks, a long symbol 134 clocks and start-of-frame 210 clocks. The acceptance windows are placed halfway between the nominal values. The block reports each assembled byte, the end of each frame with its CRC verdict, symbol errors and frame errors, each as a single-cycle pulse.

Top module: `vpw_rx`

## Requirements
- R1: An isolated receive pulse shorter than 16 clocks, surrounded by a steady level, never changes `rx_filt`. A clean level change on `rx_in` appears on `rx_filt` exactly 16 clocks later.
- R2: A filtered interval of either level shorter than 33 clocks, or an active interval longer than 248 clocks, raises `sym_err` for one cycle. It also abandons any frame in progress.
- R3: An active interval of 172 to 248 clocks is start-of-frame. It clears the bit and byte counts and loads the CRC with 0xFF. It restarts a frame even when one is in progress, and it contributes nothing to the CRC.
- R4: Inside a frame, an interval of 33 to 99 clocks is a short symbol and one of 100 to 171 clocks is a long symbol. A short passive or a long active symbol is a 1. A long passive or a short active symbol is a 0.
- R5: Bits are shifted in most significant first. After each eighth bit, `byte_valid` pulses for one cycle with the byte on `byte_data`.
- R6: A passive interval that reaches 172 clocks inside a frame is end-of-data. If the frame holds at least 2 whole bytes, `frame_done` pulses for one cycle and the frame closes.
- R7: At end-of-data, `crc_err` pulses together with `frame_done` when the CRC-8 register is not 0xC4. The CRC-8 uses polynomial 0x1D (x^8+x^4+x^3+x^2+1), starts at 0xFF and runs over all bytes including the last one. Equivalently, `crc_err` pulses when the last byte differs from the inverted CRC of the bytes before it.
- R8: Completing a thirteenth byte raises `frame_err`, does not report that byte and abandons the frame. End-of-data with a partial byte, or with fewer than 2 bytes, raises `frame_err` instead of `frame_done`.
- R9: Every event output is due exactly 18 clocks after the `rx_in` change that ends the deciding interval. For end-of-data, it is due 18 clocks after the passive interval reaches 172 clocks.
- R10: Bits and end-of-data seen outside a frame produce no byte, no `frame_done` and no error.
- R11: While `rst_n` is low and right after reset, `rx_filt` and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Synchronised receive line, 1 = active |
| rx_filt | output | 1 | Noise-filtered receive level |
| byte_valid | output | 1 | One-cycle pulse: a byte has been assembled |
| byte_data | output | 8 | Assembled byte, valid with `byte_valid` |
| frame_done | output | 1 | One-cycle pulse: frame closed by end-of-data |
| crc_err | output | 1 | CRC verdict, valid with `frame_done` |
| sym_err | output | 1 | One-cycle pulse: invalid symbol width |
| frame_err | output | 1 | One-cycle pulse: byte overflow or malformed ending |

## Verification
A level change on `rx_in` shows on `rx_filt` 16 clocks later. The decision from the interval it closes shows on the event outputs 18 clocks later: 16 in the filter, 1 in the width classifier and 1 in the deframer. End-of-data is due 18 clocks after the passive interval has lasted 172 clocks. The reference model timestamps each `rx_in` change by cycle number and files every predicted event under that cycle plus 18. It files the expected filtered level under plus 16. On every falling clock edge it compares all outputs against the entry for that cycle, which is all zero when nothing is due. A late, early or extra pulse therefore fails in the exact cycle where it appears.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

  typedef enum logic [2:0] {
    SYM_NONE = 3'd0,
    SYM_SOF  = 3'd1,
    SYM_BIT  = 3'd2,
    SYM_EOD  = 3'd3,
    SYM_INV  = 3'd4
  } sym_kind_e;

  typedef struct packed {
    sym_kind_e kind;
    logic      bit_val;
  } sym_t;

  localparam logic [7:0] CRC_SEED    = 8'hFF;
  localparam logic [7:0] CRC_POLY    = 8'h1D;
  localparam logic [7:0] CRC_RESIDUE = 8'hC4;

  // One byte through the CRC-8 register, most significant bit first.
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] r;
    r = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      if (r[7]) r = {r[6:0], 1'b0} ^ CRC_POLY;
      else      r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/vpw_rx_filter.sv
module vpw_rx_filter #(
  parameter int FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic flt_o
);
  localparam int CW = $clog2(FILT_LEN);
  localparam logic [CW-1:0] CNT_TOP = CW'(FILT_LEN - 1);

  logic [CW-1:0] cnt;
  logic          disagree;
  logic          flip;

  assign disagree = (rx_in != flt_o);
  assign flip     = disagree && (cnt == CNT_TOP);

  // Integrator: climbs while the input disagrees, decays while it agrees.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      flt_o <= 1'b0;
    end else if (flip) begin
      cnt   <= '0;
      flt_o <= rx_in;
    end else if (disagree) begin
      cnt   <= cnt + 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
    end
  end

  AST_FLIP_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_o != $past(flt_o)) |-> (flt_o == $past(rx_in))); // R1

endmodule

// File: rtl/vpw_rx_classify.sv
module vpw_rx_classify
  import vpw_rx_pkg::*;
#(
  parameter int SHORT_NOM = 67,
  parameter int LONG_NOM  = 134,
  parameter int SOF_NOM   = 210
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flt,
  output sym_t sym_o
);
  localparam int SHORT_MIN = SHORT_NOM / 2;
  localparam int SL_BND    = (SHORT_NOM + LONG_NOM) / 2;
  localparam int LS_BND    = (LONG_NOM + SOF_NOM) / 2;
  localparam int SOF_MAX   = SOF_NOM + (SOF_NOM - LONG_NOM) / 2;
  localparam int EOD_MIN   = LS_BND;
  localparam int WW        = $clog2(SOF_MAX + 2);

  logic          flt_q;
  logic [WW-1:0] wcnt;
  logic          pulse_end;
  logic          eod_hit;
  sym_t          sym_next;

  assign pulse_end = flt ^ flt_q;
  assign eod_hit   = !flt_q && (wcnt == WW'(EOD_MIN));

  // Width of a finished interval to symbol.
  function automatic sym_t judge(input logic lvl, input logic [WW-1:0] w);
    sym_t s;
    int   wi;
    wi        = int'(w);
    s.kind    = SYM_INV;
    s.bit_val = 1'b0;
    if (wi < SHORT_MIN) begin
      s.kind = SYM_INV;
    end else if (wi < SL_BND) begin
      s.kind    = SYM_BIT;
      s.bit_val = !lvl;
    end else if (wi < LS_BND) begin
      s.kind    = SYM_BIT;
      s.bit_val = lvl;
    end else if (lvl) begin
      s.kind = (wi <= SOF_MAX) ? SYM_SOF : SYM_INV;
    end else begin
      s.kind = SYM_NONE;
    end
    return s;
  endfunction

  always_comb begin
    sym_next.kind    = SYM_NONE;
    sym_next.bit_val = 1'b0;
    if (eod_hit)        sym_next.kind = SYM_EOD;
    else if (pulse_end) sym_next = judge(flt_q, wcnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      wcnt  <= '0;
      sym_o <= '0;
    end else begin
      flt_q <= flt;
      if (pulse_end)      wcnt <= WW'(1);
      else if (wcnt != '1) wcnt <= wcnt + 1'b1;
      sym_o <= sym_next;
    end
  end

  AST_EOD_AFTER_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_o.kind == SYM_EOD) |-> !$past(flt_q)); // R6
  AST_SOF_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_o.kind == SYM_SOF) |-> ($past(flt_q) && !$past(flt))); // R3
  AST_BIT_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_o.kind == SYM_BIT) |-> ($past(flt) != $past(flt_q))); // R4

endmodule

// File: rtl/vpw_rx_deframe.sv
module vpw_rx_deframe
  import vpw_rx_pkg::*;
#(
  parameter int MAX_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sym_t       sym_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_data_o,
  output logic       frame_done_o,
  output logic       crc_err_o,
  output logic       sym_err_o,
  output logic       frame_err_o
);
  localparam int BW = $clog2(MAX_BYTES + 1);
  localparam logic [BW-1:0] BYTE_CAP  = BW'(MAX_BYTES);
  localparam logic [BW-1:0] MIN_BYTES = BW'(2);

  logic          in_frame;
  logic [7:0]    shreg;
  logic [2:0]    bitcnt;
  logic [BW-1:0] bytecnt;
  logic [7:0]    crc;
  logic [7:0]    next_byte;
  logic          byte_full;

  assign next_byte = {shreg[6:0], sym_i.bit_val};
  assign byte_full = (bitcnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame     <= 1'b0;
      shreg        <= '0;
      bitcnt       <= '0;
      bytecnt      <= '0;
      crc          <= CRC_SEED;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
      frame_done_o <= 1'b0;
      crc_err_o    <= 1'b0;
      sym_err_o    <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      frame_done_o <= 1'b0;
      crc_err_o    <= 1'b0;
      sym_err_o    <= 1'b0;
      frame_err_o  <= 1'b0;
      case (sym_i.kind)
        SYM_SOF: begin
          in_frame <= 1'b1;
          bitcnt   <= '0;
          bytecnt  <= '0;
          crc      <= CRC_SEED;
        end
        SYM_BIT: if (in_frame) begin
          shreg  <= next_byte;
          bitcnt <= bitcnt + 1'b1;
          if (byte_full) begin
            if (bytecnt == BYTE_CAP) begin
              frame_err_o <= 1'b1;
              in_frame    <= 1'b0;
            end else begin
              byte_valid_o <= 1'b1;
              byte_data_o  <= next_byte;
              crc          <= crc8_byte(crc, next_byte);
              bytecnt      <= bytecnt + 1'b1;
            end
          end
        end
        SYM_EOD: if (in_frame) begin
          in_frame <= 1'b0;
          if (bitcnt != '0 || bytecnt < MIN_BYTES) begin
            frame_err_o <= 1'b1;
          end else begin
            frame_done_o <= 1'b1;
            crc_err_o    <= (crc != CRC_RESIDUE);
          end
        end
        SYM_INV: begin
          sym_err_o <= 1'b1;
          in_frame  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    bytecnt <= BYTE_CAP); // R8
  AST_CRC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_o |-> frame_done_o); // R7
  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (!frame_err_o && !sym_err_o)); // R6
  AST_BYTE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> $past(in_frame)); // R10
  AST_SYMERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err_o |-> !in_frame); // R2

endmodule

// File: rtl/vpw_rx.sv
module vpw_rx
  import vpw_rx_pkg::*;
#(
  parameter int FILT_LEN  = 16,
  parameter int SHORT_NOM = 67,
  parameter int LONG_NOM  = 134,
  parameter int SOF_NOM   = 210,
  parameter int MAX_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  output logic       rx_filt,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       frame_done,
  output logic       crc_err,
  output logic       sym_err,
  output logic       frame_err
);
  sym_t sym;

  vpw_rx_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_in (rx_in),
    .flt_o (rx_filt)
  );

  vpw_rx_classify #(
    .SHORT_NOM (SHORT_NOM),
    .LONG_NOM  (LONG_NOM),
    .SOF_NOM   (SOF_NOM)
  ) u_classify (
    .clk   (clk),
    .rst_n (rst_n),
    .flt   (rx_filt),
    .sym_o (sym)
  );

  vpw_rx_deframe #(.MAX_BYTES(MAX_BYTES)) u_deframe (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_i        (sym),
    .byte_valid_o (byte_valid),
    .byte_data_o  (byte_data),
    .frame_done_o (frame_done),
    .crc_err_o    (crc_err),
    .sym_err_o    (sym_err),
    .frame_err_o  (frame_err)
  );

  AST_EVENTS_NEED_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !(byte_valid || frame_done || sym_err || frame_err)); // R11

endmodule

// File: tb/tb_vpw_rx.sv
module tb_vpw_rx;
  localparam int CLK_PERIOD = 10;
  localparam int FL    = 16;
  localparam int LAT   = 18;
  localparam int S_MIN = 33;
  localparam int SL    = 100;
  localparam int LS    = 172;
  localparam int SOFMX = 248;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b0;
  logic rx_filt, byte_valid, frame_done, crc_err, sym_err, frame_err;
  logic [7:0] byte_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpw_rx dut (.clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_filt(rx_filt),
              .byte_valid(byte_valid), .byte_data(byte_data), .frame_done(frame_done),
              .crc_err(crc_err), .sym_err(sym_err), .frame_err(frame_err));

  int cyc = 0, n_chk = 0, n_fail = 0;
  int run_lvl = 0, run_start = 0, vsel = 0;
  bit cur_lvl = 1'b0;
  logic [12:0] exp_ev [int];
  bit clean_h [int];
  bit m_in = 1'b0;
  int m_bits = 0, m_nb = 0;
  logic [7:0] m_sh = 8'h00;
  int m_bytes[$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, expv);
    end
  endtask

  function automatic int ref_crc(input int q[$], input int n);
    int c = 255;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        int top = ((c >> 7) & 1) ^ ((q[i] >> b) & 1);
        c = (c << 1) & 255;
        if (top != 0) c = c ^ 29;
      end
    return (~c) & 255;
  endfunction

  // kind: 1 start, 2 bit, 3 end-of-data, 4 invalid
  task automatic emit(input int kind, input int bv);
    logic [12:0] v = '0;
    case (kind)
      1: begin m_in = 1'b1; m_bits = 0; m_nb = 0; m_bytes.delete(); end
      2: if (m_in) begin
        m_sh = {m_sh[6:0], bv[0]};
        m_bits++;
        if (m_bits == 8) begin
          m_bits = 0;
          if (m_nb == 12) begin v[0] = 1'b1; m_in = 1'b0; end
          else begin v[12] = 1'b1; v[11:4] = m_sh; m_nb++; m_bytes.push_back(int'(m_sh)); end
        end
      end
      3: if (m_in) begin
        m_in = 1'b0;
        if (m_bits != 0 || m_nb < 2) v[0] = 1'b1;
        else begin
          v[3] = 1'b1;
          v[2] = (m_bytes[m_nb-1] != ref_crc(m_bytes, m_nb-1));
        end
      end
      4: begin v[1] = 1'b1; m_in = 1'b0; end
      default: ;
    endcase
    if (v != '0) exp_ev[cyc + LAT] = v;
  endtask

  task automatic classify(input int lvl, input int w);
    if (lvl == 0 && w >= LS) begin
      if (w == LS) emit(3, 0);
    end else if (w < S_MIN) emit(4, 0);
    else if (w < SL) emit(2, (lvl != 0) ? 0 : 1);
    else if (w < LS) emit(2, (lvl != 0) ? 1 : 0);
    else if (w <= SOFMX) emit(1, 0);
    else emit(4, 0);
  endtask

  task automatic compare();
    logic [12:0] ev, got;
    string tag;
    bit ef;
    ev  = exp_ev.exists(cyc) ? exp_ev[cyc] : 13'h0;
    got = {byte_valid, byte_valid ? byte_data : 8'h00, frame_done, crc_err, sym_err, frame_err};
    if (ev[0] | got[0])        tag = "R8";
    else if (ev[1] | got[1])   tag = "R2";
    else if (ev[2] | got[2])   tag = "R7";
    else if (ev[3] | got[3])   tag = "R3/R6";
    else if (ev[12] | got[12]) tag = "R4/R5";
    else                       tag = "R9/R10";
    check(got == ev, tag, int'(got), int'(ev));
    ef = clean_h.exists(cyc - FL) ? clean_h[cyc - FL] : 1'b0;
    check(rx_filt == ef, "R1", int'(rx_filt), int'(ef));
  endtask

  task automatic tick(input bit r, input bit c);
    int w;
    @(negedge clk);
    cyc++;
    compare();
    w = cyc - run_start;
    if (int'(c) != run_lvl) begin
      classify(run_lvl, w);
      run_lvl = int'(c);
      run_start = cyc;
    end else if (run_lvl == 0 && w == LS) emit(3, 0);
    rx_in = r;
    clean_h[cyc] = c;
  endtask

  task automatic drive(input bit lvl, input int w, input bit gl);
    for (int i = 0; i < w; i++)
      tick((gl && i >= 40 && i < 40 + FL - 1) ? !lvl : lvl, lvl);
  endtask

  function automatic int pick(input int a, input int b, input int c);
    vsel = (vsel + 1) % 3;
    return (vsel == 0) ? a : ((vsel == 1) ? b : c);
  endfunction

  task automatic send_bits(input int val, input int n, input bit gl);
    for (int i = n - 1; i >= 0; i--) begin
      bit b = ((val >> i) & 1) != 0;
      bit longsym = cur_lvl ? b : !b;
      int w = longsym ? pick(SL, 134, LS - 1) : pick(S_MIN, 67, SL - 1);
      drive(cur_lvl, w, gl && longsym);
      cur_lvl = !cur_lvl;
    end
  endtask

  task automatic send_frame(input int q[$], input int extra, input bit gl, input int eodw);
    drive(1'b1, pick(LS, 210, SOFMX), 1'b0);
    cur_lvl = 1'b0;
    foreach (q[i]) send_bits(q[i], 8, gl);
    if (extra > 0) send_bits(10, extra, gl);
    drive(1'b0, eodw, 1'b0);
  endtask

  function automatic void make_frame(output int q[$], input int n, input bit good);
    int c;
    q.delete();
    for (int i = 0; i < n - 1; i++) q.push_back((i * 37 + 5 + n * 11) & 255);
    c = ref_crc(q, n - 1);
    q.push_back(good ? c : (c ^ 1));
  endfunction

  initial begin
    int q[$];
    repeat (4) begin
      @(negedge clk);
      check({rx_filt, byte_valid, frame_done, crc_err, sym_err, frame_err} == 6'b0,
            "R11", int'({rx_filt, byte_valid, frame_done, crc_err, sym_err, frame_err}), 0);
    end
    rst_n = 1'b1;
    drive(1'b0, 300, 1'b0);
    make_frame(q, 3, 1'b1);  send_frame(q, 0, 1'b0, 400);   // R5 R6 good frame
    make_frame(q, 3, 1'b0);  send_frame(q, 0, 1'b0, 400);   // R7 bad CRC
    make_frame(q, 12, 1'b1); send_frame(q, 0, 1'b0, 400);   // R8 limit reached, still fine
    make_frame(q, 13, 1'b1); send_frame(q, 0, 1'b0, 400);   // R8 overflow
    make_frame(q, 1, 1'b1);  send_frame(q, 0, 1'b0, 400);   // R8 too short
    make_frame(q, 2, 1'b1);  send_frame(q, 4, 1'b0, 400);   // R8 partial byte
    make_frame(q, 4, 1'b1);  send_frame(q, 0, 1'b1, LS);    // R1 glitches, R6 end at exact bound
    make_frame(q, 5, 1'b1);  send_frame(q, 0, 1'b0, 400);   // R3 start right after end
    drive(1'b1, 20, 1'b0);  drive(1'b0, 300, 1'b0);         // R2 narrow active
    drive(1'b1, 260, 1'b0); drive(1'b0, 300, 1'b0);         // R2 overlong active
    drive(1'b1, 67, 1'b0);  drive(1'b0, 67, 1'b0);          // R10 bits with no frame
    drive(1'b1, 134, 1'b0); drive(1'b0, 400, 1'b0);
    drive(1'b1, 210, 1'b0); cur_lvl = 1'b0;                 // R2 short passive gap in frame
    send_bits(85, 8, 1'b0);
    drive(1'b0, 20, 1'b0);
    drive(1'b1, 67, 1'b0);  drive(1'b0, 67, 1'b0);
    drive(1'b1, 134, 1'b0); drive(1'b0, 400, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R9 actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule